// File: doc/BRIEF.md
# Interrupting Message Capture Buffer

This block catches one status message that arrives as a stream of 32-bit words with an end marker. It holds the words in a small on-chip store until software has read them out. Software arms the buffer through a two-bit control write. While armed, the buffer takes words from a valid/ready stream. When the marked final word arrives, the buffer stops taking input, reports completion and the word count in a status word, and raises a level interrupt. Software then reads the captured words at consecutive word addresses from zero. To prepare for the next message it issues a clear, polls the idle flag and issues a start.

If a message fills every slot before its end marker, the buffer flags an error instead of completion. It stops writing and still reports how many words it holds. The stream interface follows the usual rules. A transfer happens on a cycle where both `in_valid` and `in_ready` are high. The source may hold `in_valid` high with steady data while `in_ready` is low. In that case nothing is consumed, and the word is taken later once the buffer is armed again. `in_ready` is high only while the buffer is armed.

Top module: `msgcap_top`

## Requirements
- R1: After reset the buffer is idle: `status_word` equals 0x0000_0004, `irq` is low and `in_ready` is low.
- R2: A control write with bit 0 set (clear) returns the buffer to idle with count 0 on the next cycle, whatever its state. Clear takes priority when bits 0 and 1 are both set. A word offered in the same cycle as a clear is dropped.
- R3: A control write with bit 1 set (start) while idle arms the buffer. A start written while the buffer is done or in error is ignored.
- R4: While armed, `in_ready` is high. Each transfer stores the word at index equal to the current count, and the count rises by one. The count is reported in `status_word[31:16]`.
- R5: While idle, done or in error, `in_ready` is low. Offered words are neither stored nor counted, and the source may hold them with `in_valid` high until a later arm accepts them.
- R6: A transfer with `in_last` high enters done on the next cycle: `status_word[0]` is set and `in_ready` drops.
- R7: If the word that fills the last of DEPTH slots has `in_last` low, the buffer enters error on the next cycle: `status_word[1]` is set, the count is DEPTH, and no further word is accepted.
- R8: `status_word[2]` is set only while idle. Bits [15:3] always read zero, and bits [1:0] are zero except in done and error.
- R9: `irq` is high exactly while done or error holds, and it is low on the cycle after a clear.
- R10: `rd_data` shows, one cycle after `rd_addr` is presented, the word stored at that index. An address of DEPTH or above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 2 | Control bits: bit 0 clear, bit 1 start |
| status_word | output | 32 | Count [31:16], idle [2], error [1], done [0] |
| irq | output | 1 | Level interrupt, high while done or error |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word ready (armed only) |
| in_data | input | DATA_W | Stream word |
| in_last | input | 1 | Final word of the message |
| rd_addr | input | $clog2(DEPTH)+1 | Readout word index |
| rd_data | output | DATA_W | Readout word, one cycle after address |

## Verification
The bench builds the buffer with DEPTH = 8 and DATA_W = 32. With this depth, a message of exactly the full length and a message that overruns it are both short, so both the done and error paths come up many times in the random runs. The readout index is one bit wider than the store needs, so the bench can reach addresses of DEPTH and above and check that they read zero. Random message lengths span 1 to DEPTH+3 with random gaps between words. Directed cases cover clears during capture, combined clear and start, and a word held back under back-pressure.

// File: rtl/msgcap_pkg.sv
package msgcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERR   = 2'd3
  } cap_state_t;

  localparam int CTRL_CLR_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_IDLE_BIT = 2;
  localparam int STAT_CNT_LSB  = 16;
  localparam int STAT_CNT_W    = 16;
endpackage

// File: rtl/msgcap_fsm.sv
module msgcap_fsm
  import msgcap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_cmd,
  input  logic          arm_cmd,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output cap_state_t    state_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST_IDX  = CW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_CNT = CW'(DEPTH);

  cap_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;
  logic          arm_eff;

  assign in_ready = (state_q == ST_ARMED);
  assign accept   = in_valid && in_ready;
  assign arm_eff  = arm_cmd && !clr_cmd;
  assign wr_en    = accept && !clr_cmd;
  assign wr_idx   = cnt_q[AW-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr_cmd) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_eff) state_d = ST_ARMED;
        ST_ARMED: begin
          if (accept) begin
            cnt_d = cnt_q + CW'(1);
            if (in_last)                state_d = ST_DONE;
            else if (cnt_q == LAST_IDX) state_d = ST_ERR;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr_cmd) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r6_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last && !clr_cmd) |=> (state_q == ST_DONE && !in_ready));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= DEPTH_CNT));

  a_r7_full_error: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_last && !clr_cmd && cnt_q == LAST_IDX) |=> (state_q == ST_ERR && cnt_q == DEPTH_CNT));

  a_r2_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (state_q == ST_IDLE && cnt_q == '0));

  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_cmd && !clr_cmd && (state_q == ST_DONE || state_q == ST_ERR)) |=> $stable(state_q));
endmodule

// File: rtl/msgcap_store.sv
module msgcap_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(DEPTH),
  parameter int RA_W   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [RA_W-1:0] DEPTH_A = RA_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                rd_data <= '0;
    else if (rd_addr < DEPTH_A) rd_data <= mem[rd_addr[AW-1:0]];
    else                        rd_data <= '0;
  end

  a_r10_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= DEPTH_A) |=> (rd_data == '0));
endmodule

// File: rtl/msgcap_status.sv
module msgcap_status
  import msgcap_pkg::*;
#(
  parameter int CW = 5
) (
  input  cap_state_t    state_i,
  input  logic [CW-1:0] cnt_i,
  output logic [31:0]   status_word,
  output logic          irq
);
  always_comb begin
    status_word = '0;
    status_word[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(cnt_i);
    status_word[STAT_DONE_BIT] = (state_i == ST_DONE);
    status_word[STAT_ERR_BIT]  = (state_i == ST_ERR);
    status_word[STAT_IDLE_BIT] = (state_i == ST_IDLE);
  end

  assign irq = (state_i == ST_DONE) || (state_i == ST_ERR);
endmodule

// File: rtl/msgcap_top.sv
module msgcap_top
  import msgcap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctrl_we,
  input  logic [1:0]                 ctrl_wdata,
  output logic [31:0]                status_word,
  output logic                       irq,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_last,
  input  logic [$clog2(DEPTH):0]     rd_addr,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int RA_W = AW + 1;

  logic          clr_cmd, arm_cmd, wr_en;
  logic [AW-1:0] wr_idx;
  cap_state_t    state;
  logic [CW-1:0] cnt;

  assign clr_cmd = ctrl_we && ctrl_wdata[CTRL_CLR_BIT];
  assign arm_cmd = ctrl_we && ctrl_wdata[CTRL_ARM_BIT];

  msgcap_fsm #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .arm_cmd(arm_cmd),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .state_o(state), .cnt_o(cnt)
  );

  msgcap_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW), .RA_W(RA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(in_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  msgcap_status #(.CW(CW)) u_status (
    .state_i(state), .cnt_i(cnt), .status_word(status_word), .irq(irq)
  );

  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (!irq && status_word[STAT_IDLE_BIT]));

  a_r5_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || status_word[STAT_IDLE_BIT]) |-> !in_ready);
endmodule

// File: tb/msgcap_top_bench.sv
module msgcap_top_bench;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int RA_W   = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrl_we = 1'b0;
  logic [1:0]        ctrl_wdata = '0;
  logic [31:0]       status_word;
  logic              irq;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_last = 1'b0;
  logic [RA_W-1:0]   rd_addr = '0;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [DATA_W-1:0] exp_mem [DEPTH];

  always #4 clk = ~clk;

  msgcap_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_msgcap_top (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .status_word(status_word), .irq(irq), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] exp_status(int cnt, bit idle, bit err, bit done);
    logic [31:0] s;
    s = '0;
    s[31:16] = 16'(cnt);
    s[2] = idle; s[1] = err; s[0] = done;
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [1:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic clear_arm();
    wr_ctrl(2'b01);
    for (int i = 0; i < 10 && !status_word[2]; i++) @(negedge clk);
    wr_ctrl(2'b10);
  endtask

  // offers one word; returns whether it was taken at the next edge
  task automatic send_word(logic [DATA_W-1:0] d, bit l, output bit acc);
    in_valid = 1'b1; in_data = d; in_last = l;
    #1 acc = in_ready;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // sends n words (last flag only when !ovf); returns words accepted
  task automatic send_msg(int n, bit ovf, bit gaps, output int taken);
    bit acc;
    taken = 0;
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] d;
      d = $urandom;
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      send_word(d, (i == n - 1) && !ovf, acc);
      if (!acc) break;
      exp_mem[taken] = d;
      taken++;
    end
  endtask

  task automatic rd(int a, output logic [DATA_W-1:0] v);
    rd_addr = RA_W'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_readout(string req, int n);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < n; i++) begin
      rd(i, v);
      chk(req, v, exp_mem[i]);
    end
  endtask

  initial begin
    repeat (3000) @(negedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int taken;
    bit acc;
    logic [DATA_W-1:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", status_word, 32'h4);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ready", {31'b0, in_ready}, 32'h0);

    // R5 words while idle are ignored
    send_word(32'hDEAD_BEEF, 1'b1, acc);
    chk("R5 idle refuse", {31'b0, acc}, 32'h0);
    chk("R5 idle count", status_word, 32'h4);

    // R3 arm, R8 armed status
    clear_arm();
    chk("R8 armed status", status_word, exp_status(0, 0, 0, 0));
    chk("R4 ready armed", {31'b0, in_ready}, 32'h1);

    // R6 single-word message
    send_msg(1, 0, 0, taken);
    chk("R6 done status", status_word, exp_status(1, 0, 0, 1));
    chk("R6 ready low", {31'b0, in_ready}, 32'h0);
    chk("R9 irq done", {31'b0, irq}, 32'h1);
    check_readout("R10 readout", 1);

    // R3 start ignored while done
    wr_ctrl(2'b10);
    chk("R3 start ignored", status_word, exp_status(1, 0, 0, 1));

    // R9 / R2 clear drops irq
    wr_ctrl(2'b01);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    chk("R2 clear status", status_word, 32'h4);

    // R4 / R6 exact-depth message
    clear_arm();
    send_msg(DEPTH, 0, 1, taken);
    chk("R4 taken", 32'(taken), 32'(DEPTH));
    chk("R6 full done", status_word, exp_status(DEPTH, 0, 0, 1));
    check_readout("R10 full readout", DEPTH);

    // R7 overflow
    clear_arm();
    send_msg(DEPTH + 2, 1, 0, taken);
    chk("R7 taken", 32'(taken), 32'(DEPTH));
    chk("R7 error status", status_word, exp_status(DEPTH, 0, 1, 0));
    chk("R9 irq error", {31'b0, irq}, 32'h1);
    check_readout("R7 store intact", DEPTH);
    rd(DEPTH, v);
    chk("R10 range zero", v, 32'h0);
    rd(2 * DEPTH - 1, v);
    chk("R10 range zero top", v, 32'h0);

    // R2 clear mid-message
    clear_arm();
    send_msg(3, 1, 0, taken);
    chk("R4 partial count", status_word, exp_status(3, 0, 0, 0));
    wr_ctrl(2'b01);
    chk("R2 clear mid", status_word, 32'h4);

    // R2 clear wins over start
    wr_ctrl(2'b11);
    chk("R2 clear priority", status_word, 32'h4);

    // R5 back-pressure: held word taken after re-arm
    clear_arm();
    send_msg(2, 0, 0, taken);
    in_valid = 1'b1; in_data = 32'hCAFE_0123; in_last = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 held not taken", status_word, exp_status(2, 0, 0, 1));
    ctrl_we = 1'b1; ctrl_wdata = 2'b01; @(negedge clk);
    ctrl_wdata = 2'b10; @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R5 held taken", status_word, exp_status(1, 0, 0, 1));
    rd(0, v);
    chk("R5 held data", v, 32'hCAFE_0123);

    // random messages
    for (int it = 0; it < 40; it++) begin
      int len;
      bit ovf;
      len = $urandom_range(1, DEPTH + 3);
      ovf = (len > DEPTH);
      clear_arm();
      send_msg(len, ovf, 1, taken);
      if (ovf) begin
        chk("R7 random", status_word, exp_status(DEPTH, 0, 1, 0));
        check_readout("R10 random", DEPTH);
      end else begin
        chk("R6 random", status_word, exp_status(len, 0, 0, 1));
        check_readout("R10 random", len);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule